// File: doc/BRIEF.md
# 8x8 Key Matrix Scanner

This block scans a matrix of 64 switches one intersection per cycle. It puts a 3-bit column code on its pins together with the decoded active-low column lines, so one column is pulled low at a time. It also puts a 3-bit select on the pins that picks one row line for an external 8-to-1 selector, and that selector returns a single row bit. Rows idle high through pull-ups. A low on the chosen row therefore means that the switch at that crossing is closed.

The row select is the inner loop and the column code is the outer loop. Each time the column code changes, one settle cycle passes before the first row is sampled. For each closed switch found, the block raises a single-cycle strobe with a 6-bit key code. Scanning never stops, so any number of pressed keys are all reported within one frame. A frame-done pulse marks the end of each full pass, and the scan then restarts at the upper-left corner. Per-key debouncing and ghost suppression belong to the logic that consumes the strobes.

Top module: `kmx_scanner`

## Requirements
- R1: While rst_ni is low, col_code_o and row_sel_o read 0, col_n_o reads 8'hFE, and key_valid_o and frame_done_o are low.
- R2: col_n_o has exactly one bit low at all times, and that bit is at index col_code_o.
- R3: row_sel_o only holds or steps by +1 modulo 8. It runs 0 to 7 within each column before col_code_o advances.
- R4: When a sampled row bit is 0, key_valid_o is high in the next cycle and key_code_o equals {column, row} of that sample, with the column in bits 5:3 and the row in bits 2:0. Code 0 is column 0 row 0 and code 63 is column 7 row 7. A row bit of 1 gives no strobe.
- R5: The row bit is ignored during the settle cycle that follows every column change, so a low on row_bit_i during that cycle produces no strobe.
- R6: frame_done_o is a single-cycle pulse. It comes in the cycle after step 63 is sampled and repeats every 72 cycles (8 columns times 8 rows plus 1 settle cycle).
- R7: Each closed key is reported exactly once per frame by a one-cycle strobe, in ascending code order, so the number of strobes equals the number of closed keys.
- R8: In the cycle where frame_done_o is high, the scan has wrapped to col_code_o = 0 and row_sel_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_bit_i | input | 1 | Selected row line, low when the switch is closed |
| col_code_o | output | 3 | Column code under scan |
| col_n_o | output | 8 | Decoded column drive, active low |
| row_sel_o | output | 3 | Row selector code |
| key_valid_o | output | 1 | One-cycle strobe for a closed key |
| key_code_o | output | 6 | {column, row} of the reported key |
| frame_done_o | output | 1 | Pulse at the end of a full 64-step pass |

## Verification
The bench models a switch matrix that answers the block's column and row outputs. It also pulls the row line low during the cycle that follows each column change. An empty matrix under that pull shows whether the settle cycle is honoured. Single keys at code 0, code 63 and code 21 show that the corners are reached and that the column sits in the upper code bits. A full column, a row spread across all columns, a checkerboard and an all-closed matrix test reporting of many keys per frame, the strobe count and the ordering. A reset in the middle of a frame shows that the scan restarts cleanly.

// File: rtl/kmx_pkg.sv
package kmx_pkg;
  parameter int unsigned KMX_SEL_W  = 3;
  parameter int unsigned KMX_SETTLE = 1;

  typedef enum logic {
    PH_SETTLE = 1'b0,
    PH_SAMPLE = 1'b1
  } kmx_phase_e;
endpackage

// File: rtl/kmx_seq.sv
module kmx_seq #(
  parameter int unsigned COL_W      = 3,
  parameter int unsigned ROW_W      = 3,
  parameter int unsigned SETTLE_CYC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output kmx_pkg::kmx_phase_e phase_o,
  output logic             last_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] settle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q    <= '0;
      row_q    <= '0;
      settle_q <= CNT_W'(SETTLE_CYC);
    end else if (settle_q != '0) begin
      settle_q <= settle_q - 1'b1;
    end else if (row_q == '1) begin
      row_q    <= '0;
      col_q    <= col_q + 1'b1;
      settle_q <= CNT_W'(SETTLE_CYC);
    end else begin
      row_q <= row_q + 1'b1;
    end
  end

  assign col_o   = col_q;
  assign row_o   = row_q;
  assign phase_o = (settle_q == '0) ? kmx_pkg::PH_SAMPLE : kmx_pkg::PH_SETTLE;
  assign last_o  = (settle_q == '0) && (col_q == '1) && (row_q == '1);
endmodule

// File: rtl/kmx_col_dec.sv
module kmx_col_dec #(
  parameter int unsigned COL_W = 3
) (
  input  logic [COL_W-1:0]      col_i,
  output logic [2**COL_W-1:0]   col_n_o
);
  for (genvar i = 0; i < 2**COL_W; i++) begin : g_col
    assign col_n_o[i] = (col_i != COL_W'(i));
  end
endmodule

// File: rtl/kmx_detect.sv
module kmx_detect #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  kmx_pkg::kmx_phase_e phase_i,
  input  logic              last_i,
  input  logic              row_bit_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);
  logic sample;
  assign sample = (phase_i == kmx_pkg::PH_SAMPLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      valid_o <= sample && !row_bit_i;
      done_o  <= last_i;
      if (sample && !row_bit_i) code_o <= code_i;
    end
  end
endmodule

// File: rtl/kmx_scanner.sv
module kmx_scanner #(
  parameter int unsigned COL_W      = kmx_pkg::KMX_SEL_W,
  parameter int unsigned ROW_W      = kmx_pkg::KMX_SEL_W,
  parameter int unsigned SETTLE_CYC = kmx_pkg::KMX_SETTLE,
  localparam int unsigned CODE_W    = COL_W + ROW_W,
  localparam int unsigned N_COL     = 2**COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              row_bit_i,
  output logic [COL_W-1:0]  col_code_o,
  output logic [N_COL-1:0]  col_n_o,
  output logic [ROW_W-1:0]  row_sel_o,
  output logic              key_valid_o,
  output logic [CODE_W-1:0] key_code_o,
  output logic              frame_done_o
);
  kmx_pkg::kmx_phase_e phase;
  logic last;

  kmx_seq #(.COL_W(COL_W), .ROW_W(ROW_W), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .col_o   (col_code_o),
    .row_o   (row_sel_o),
    .phase_o (phase),
    .last_o  (last)
  );

  kmx_col_dec #(.COL_W(COL_W)) u_dec (
    .col_i   (col_code_o),
    .col_n_o (col_n_o)
  );

  kmx_detect #(.CODE_W(CODE_W)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase),
    .last_i    (last),
    .row_bit_i (row_bit_i),
    .code_i    ({col_code_o, row_sel_o}),
    .valid_o   (key_valid_o),
    .code_o    (key_code_o),
    .done_o    (frame_done_o)
  );
endmodule

// File: rtl/kmx_scanner_chk.sv
module kmx_scanner_chk #(
  parameter int unsigned COL_W  = 3,
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned CODE_W = 6,
  parameter int unsigned N_COL  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              row_bit_i,
  input logic [COL_W-1:0]  col_code_o,
  input logic [N_COL-1:0]  col_n_o,
  input logic [ROW_W-1:0]  row_sel_o,
  input logic              key_valid_o,
  input logic [CODE_W-1:0] key_code_o,
  input logic              frame_done_o
);
  // R2
  col_onecold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(~col_n_o) == 1) && !col_n_o[col_code_o]);

  // R3
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_sel_o != $past(row_sel_o)) |-> (row_sel_o == ROW_W'($past(row_sel_o) + 1'b1)));

  // R4
  key_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> (!$past(row_bit_i) && key_code_o == $past({col_code_o, row_sel_o})));

  // R5
  settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_code_o != $past(col_code_o)) |=> !key_valid_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  // R8
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (col_code_o == '0 && row_sel_o == '0));
endmodule

bind kmx_scanner kmx_scanner_chk #(
  .COL_W(COL_W), .ROW_W(ROW_W), .CODE_W(CODE_W), .N_COL(N_COL)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .row_bit_i    (row_bit_i),
  .col_code_o   (col_code_o),
  .col_n_o      (col_n_o),
  .row_sel_o    (row_sel_o),
  .key_valid_o  (key_valid_o),
  .key_code_o   (key_code_o),
  .frame_done_o (frame_done_o)
);

// File: tb/kmx_scanner_test.sv
module kmx_scanner_test;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_LEN  = 8 * (8 + 1);

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       row_bit;
  logic [2:0] col_code;
  logic [7:0] col_n;
  logic [2:0] row_sel;
  logic       key_valid;
  logic [5:0] key_code;
  logic       frame_done;

  logic [63:0] matrix = '0;
  logic        glitch = 1'b0;
  logic [2:0]  col_seen = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kmx_scanner uut (
    .clk_i(clk), .rst_ni(rst_ni), .row_bit_i(row_bit),
    .col_code_o(col_code), .col_n_o(col_n), .row_sel_o(row_sel),
    .key_valid_o(key_valid), .key_code_o(key_code), .frame_done_o(frame_done)
  );

  // switch matrix model; row line is disturbed low right after a column change
  assign row_bit = glitch ? 1'b0 : ~matrix[{col_code, row_sel}];

  // per-frame monitor
  logic [63:0] acc_mask, lf_mask;
  int acc_strb, acc_order, acc_col, acc_row, cyc;
  int lf_strb, lf_order, lf_col, lf_row, lf_len, lf_wrap;
  int last_code;
  logic [2:0] prev_row;
  int frames = 0;

  always @(negedge clk) begin
    glitch   <= (col_code != col_seen);
    col_seen <= col_code;
    if (!rst_ni) begin
      acc_mask = '0; acc_strb = 0; acc_order = 0; acc_col = 0; acc_row = 0;
      cyc = 0; last_code = -1; prev_row = '0;
    end else begin
      cyc++;
      if (col_n != ~(8'd1 << col_code)) acc_col++;
      if (row_sel != prev_row && row_sel != prev_row + 3'd1) acc_row++;
      prev_row = row_sel;
      if (key_valid) begin
        if (int'(key_code) <= last_code || acc_mask[key_code]) acc_order++;
        acc_mask[key_code] = 1'b1;
        acc_strb++;
        last_code = int'(key_code);
      end
      if (frame_done) begin
        lf_mask = acc_mask; lf_strb = acc_strb; lf_order = acc_order;
        lf_col = acc_col; lf_row = acc_row; lf_len = cyc;
        lf_wrap = (col_code == 3'd0 && row_sel == 3'd0) ? 0 : 1;
        acc_mask = '0; acc_strb = 0; acc_order = 0; acc_col = 0; acc_row = 0;
        cyc = 0; last_code = -1;
        frames++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_frame();
    int n = frames;
    wait (frames != n);
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(col_code == 3'd0, "R1", "col_code in reset", col_code, 0);
    check(row_sel == 3'd0, "R1", "row_sel in reset", row_sel, 0);
    check(col_n == 8'hFE, "R1", "col_n in reset", col_n, 8'hFE);
    check(!key_valid && !frame_done, "R1", "strobes in reset",
          {key_valid, frame_done}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic run_pattern(input logic [63:0] mask, input string req);
    wait_frame();
    matrix = mask;
    wait_frame();
    check(lf_mask == mask, req, "reported key set", lf_mask, mask);
    check(lf_strb == $countones(mask), "R7", "strobe count", lf_strb, $countones(mask));
    check(lf_order == 0, "R7", "ascending order", lf_order, 0);
    check(lf_len == FRAME_LEN, "R6", "frame length", lf_len, FRAME_LEN);
    check(lf_col == 0, "R2", "column drive errors", lf_col, 0);
    check(lf_row == 0, "R3", "row step errors", lf_row, 0);
    check(lf_wrap == 0, "R8", "wrap at frame end", lf_wrap, 0);
  endtask

  task automatic test_mid_reset();
    repeat (37) @(negedge clk);
    test_reset();
  endtask

  initial begin
    test_reset();
    run_pattern(64'h0, "R5");                    // only settle-cycle lows present
    run_pattern(64'h1, "R4");                    // code 0: col 0 row 0
    run_pattern(64'h8000_0000_0000_0000, "R4");  // code 63
    run_pattern(64'h1 << 21, "R4");              // col 2 row 5
    run_pattern(64'h0000_FF00_0000_0000, "R7");  // full column 5
    run_pattern(64'h0101_0101_0101_0101, "R5");  // row 0 of every column
    run_pattern(64'hAA55_AA55_AA55_AA55, "R7");
    test_mid_reset();
    run_pattern(64'hFFFF_FFFF_FFFF_FFFF, "R7");
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule